// File: doc/BRIEF.md
# Relocatable Shared RAM Window Decoder

This block decides whether a host memory address lands in a movable window onto a 64 KB shared RAM, and converts that address into a RAM byte address. A relocation register sets the window base in 8 KB steps. A strap input fixes the window size at 8, 16, 32 or 64 KB, and a read-only view of it is returned to the register bank. A paging register, when armed, picks which slice of the RAM shows through a window smaller than the whole RAM.

The hit flag and the RAM address are pure combinational functions of the host address and the stored configuration. The lookup never stalls, so the host side has no ready signal and `host_valid` simply marks the cycles that carry an access. An access that falls inside the 64 KB aligned region holding the window, but outside the window itself, raises a one-cycle violation pulse. The register bank uses that pulse to post an access-violation interrupt. Configuration writes use a plain write strobe with a one-bit register select.

Top module: `shwin_top`

## Requirements
- R1: After reset, both configuration registers read as zero. The window base is 0x00000 and paging is off. With size code 0, address 0x00010 hits and maps to RAM 0x0010, address 0x02000 misses, and `viol` is low.
- R2: Bits 7:1 of the relocation register (select 0) become host address bits 19:13 of the window base. Bit 0 is ignored.
- R3: `win_size_rd` carries `size_code` in bits 3:2, and every other bit is zero. Configuration writes do not change it.
- R4: `hit` is 1 exactly when the host address bits at and above bit 13+size_code equal the same bits of the base. Base bits below that position are ignored. The codes are 0 = 8 KB, 1 = 16 KB, 2 = 32 KB and 3 = 64 KB.
- R5: With paging off, `ram_addr` is the host address modulo the window size, and all bits above the offset are zero.
- R6: Writing the paging register (select 1) with bits 7:6 = 11 turns paging on. Its bits 2:0, shifted left by 13+size_code, fill the RAM address bits above the offset, and bits shifted past bit 15 are dropped.
- R7: A paging register value whose bits 7:6 are not 11 leaves paging off, and `ram_addr` behaves as in R5.
- R8: `viol` goes high one cycle after an edge at which `host_valid` is 1 and the address has bits 19:16 equal to the base's bits 19:16 but misses the window. It stays high for that one cycle only. Nothing raises it without `host_valid`.
- R9: With size code 3, `viol` never rises, and the page number has no effect on `ram_addr`.
- R10: A configuration write takes effect at the clock edge that samples `cfg_we`. Until that edge, the lookup uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the relocation register, 1 selects the paging register |
| cfg_wdata | input | 8 | Configuration write data |
| size_code | input | 2 | Strapped window size code |
| host_addr | input | 20 | Host memory address |
| host_valid | input | 1 | The host drives an access this cycle |
| win_size_rd | output | 8 | Read-only size view, code in bits 3:2 |
| hit | output | 1 | Address lies inside the window |
| ram_addr | output | 16 | Translated shared RAM byte address |
| viol | output | 1 | One-cycle access-violation pulse |

## Verification
`hit`, `ram_addr` and `win_size_rd` settle in the same cycle as the address or size code. The bench therefore changes them on a falling edge and samples 1 ns later, before any rising edge. A configuration write is due at the first rising edge after the strobe. The bench checks the old mapping just before that edge and the new one at the following falling edge. `viol` arrives one rising edge after the offending access. The bench samples it at the next falling edge, then samples again one cycle later to confirm the pulse has ended.

// File: rtl/shwin_pkg.sv
package shwin_pkg;
  localparam int HOST_AW_D = 20;
  localparam int RAM_AW_D  = 16;
  localparam int MIN_AW_D  = 13;
  localparam int SZ_W_D    = 2;
  localparam int CFG_W_D   = 8;
  localparam logic [1:0] PG_ARM_KEY = 2'b11;
  typedef enum logic { SEL_RELOC = 1'b0, SEL_PAGE = 1'b1 } cfg_sel_e;
endpackage

// File: rtl/shwin_cfg.sv
module shwin_cfg
  import shwin_pkg::*;
#(
  parameter int CFG_W  = CFG_W_D,
  parameter int BASE_W = 7,
  parameter int PAGE_W = 3,
  parameter bit PAGING = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [CFG_W-1:0]  wdata,
  output logic [BASE_W-1:0] base_hi,
  output logic              pg_active,
  output logic [PAGE_W-1:0] page_num
);
  logic [BASE_W-1:0] reloc_q;
  logic unused_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) reloc_q <= '0;
    else if (we && sel == SEL_RELOC) reloc_q <= wdata[BASE_W:1];
  end
  assign base_hi = reloc_q;

  generate
    if (PAGING) begin : g_page
      logic [CFG_W-1:0] page_q;
      always_ff @(posedge clk) begin
        if (!rst_n) page_q <= '0;
        else if (we && sel == SEL_PAGE) page_q <= wdata;
      end
      assign pg_active   = page_q[CFG_W-1 -: 2] == PG_ARM_KEY;
      assign page_num    = page_q[PAGE_W-1:0];
      assign unused_bits = ^{wdata[0], page_q[CFG_W-3:PAGE_W]};

      // R10
      page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_PAGE) |=> (page_num == $past(wdata[PAGE_W-1:0])));
    end else begin : g_nopage
      assign pg_active   = 1'b0;
      assign page_num    = '0;
      assign unused_bits = wdata[0];
    end
  endgenerate

  // R10
  reloc_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_RELOC) |=> (base_hi == $past(wdata[BASE_W:1])));
endmodule

// File: rtl/shwin_match.sv
module shwin_match #(
  parameter int HOST_AW = 20,
  parameter int RAM_AW  = 16,
  parameter int MIN_AW  = 13,
  parameter int SZ_W    = 2
) (
  input  logic [HOST_AW-1:0]        host_addr,
  input  logic [HOST_AW-MIN_AW-1:0] base_hi,
  input  logic [SZ_W-1:0]           size_code,
  output logic [HOST_AW-1:0]        win_mask,
  output logic                      hit,
  output logic                      in_aperture
);
  logic [HOST_AW-1:0] base_addr;

  always_comb begin
    base_addr   = {base_hi, {MIN_AW{1'b0}}};
    win_mask    = (HOST_AW'(1) << (MIN_AW + int'(size_code))) - HOST_AW'(1);
    hit         = ((host_addr ^ base_addr) & ~win_mask) == '0;
    in_aperture = host_addr[HOST_AW-1:RAM_AW] == base_addr[HOST_AW-1:RAM_AW];
  end
endmodule

// File: rtl/shwin_xlate.sv
module shwin_xlate #(
  parameter int RAM_AW = 16,
  parameter int MIN_AW = 13,
  parameter int SZ_W   = 2,
  parameter int PAGE_W = 3
) (
  input  logic [RAM_AW-1:0] addr_lo,
  input  logic [RAM_AW-1:0] mask_lo,
  input  logic              pg_active,
  input  logic [PAGE_W-1:0] page_num,
  input  logic [SZ_W-1:0]   size_code,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [RAM_AW-1:0] page_term;

  always_comb begin
    page_term = '0;
    if (pg_active) page_term = RAM_AW'(page_num) << (MIN_AW + int'(size_code));
    ram_addr = (addr_lo & mask_lo) | page_term;
  end
endmodule

// File: rtl/shwin_top.sv
module shwin_top
  import shwin_pkg::*;
#(
  parameter int HOST_AW = HOST_AW_D,
  parameter int RAM_AW  = RAM_AW_D,
  parameter int MIN_AW  = MIN_AW_D,
  parameter int SZ_W    = SZ_W_D,
  parameter int CFG_W   = CFG_W_D,
  parameter bit PAGING  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [SZ_W-1:0]    size_code,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_valid,
  output logic [CFG_W-1:0]   win_size_rd,
  output logic               hit,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               viol
);
  localparam int BASE_W = HOST_AW - MIN_AW;
  localparam int PAGE_W = RAM_AW - MIN_AW;

  logic [BASE_W-1:0]  base_hi;
  logic               pg_active;
  logic [PAGE_W-1:0]  page_num;
  logic [HOST_AW-1:0] win_mask;
  logic               in_aperture;
  logic               unused_mask;

  shwin_cfg #(.CFG_W(CFG_W), .BASE_W(BASE_W), .PAGE_W(PAGE_W), .PAGING(PAGING)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_hi(base_hi), .pg_active(pg_active), .page_num(page_num));

  shwin_match #(.HOST_AW(HOST_AW), .RAM_AW(RAM_AW), .MIN_AW(MIN_AW), .SZ_W(SZ_W)) match_i (
    .host_addr(host_addr), .base_hi(base_hi), .size_code(size_code),
    .win_mask(win_mask), .hit(hit), .in_aperture(in_aperture));

  shwin_xlate #(.RAM_AW(RAM_AW), .MIN_AW(MIN_AW), .SZ_W(SZ_W), .PAGE_W(PAGE_W)) xlate_i (
    .addr_lo(host_addr[RAM_AW-1:0]), .mask_lo(win_mask[RAM_AW-1:0]),
    .pg_active(pg_active), .page_num(page_num), .size_code(size_code),
    .ram_addr(ram_addr));

  assign unused_mask = ^win_mask[HOST_AW-1:RAM_AW];
  assign win_size_rd = CFG_W'({size_code, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= host_valid && in_aperture && !hit;
  end

  // R8
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> ($past(host_valid) && !$past(hit)));
  // R9
  full_win_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == '1) |=> !viol);
  // R4
  hit_in_aperture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (host_addr[HOST_AW-1:RAM_AW] == base_hi[BASE_W-1:RAM_AW-MIN_AW]));
  // R5
  flat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_active |-> ((ram_addr & ~win_mask[RAM_AW-1:0]) == '0));
endmodule

// File: tb/shwin_top_tb_top.sv
`timescale 1ns/1ps
module shwin_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, host_valid = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] size_code = '0;
  logic [19:0] host_addr = '0;
  logic [7:0] win_size_rd;
  logic hit, viol;
  logic [15:0] ram_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  shwin_top dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .size_code(size_code), .host_addr(host_addr),
    .host_valid(host_valid), .win_size_rd(win_size_rd), .hit(hit),
    .ram_addr(ram_addr), .viol(viol));

  // {reloc, page, size, addr, hit, ram, pad}
  localparam logic [63:0] VEC [0:13] = '{
    {8'h00, 8'h00, 2'd0, 20'h01234, 1'b1, 16'h1234, 9'd0},
    {8'h14, 8'h00, 2'd0, 20'h15ABC, 1'b1, 16'h1ABC, 9'd0},
    {8'h14, 8'h00, 2'd0, 20'h16000, 1'b0, 16'h0000, 9'd0},
    {8'h15, 8'h00, 2'd0, 20'h14010, 1'b1, 16'h0010, 9'd0},
    {8'h16, 8'h00, 2'd1, 20'h17FFF, 1'b1, 16'h3FFF, 9'd0},
    {8'hFE, 8'h00, 2'd2, 20'hF8001, 1'b1, 16'h0001, 9'd0},
    {8'hFE, 8'h00, 2'd2, 20'hF0000, 1'b0, 16'h0000, 9'd0},
    {8'h20, 8'h00, 2'd3, 20'h2ABCD, 1'b1, 16'hABCD, 9'd0},
    {8'h14, 8'hC5, 2'd0, 20'h15ABC, 1'b1, 16'hBABC, 9'd0},
    {8'h14, 8'hC7, 2'd1, 20'h17FFF, 1'b1, 16'hFFFF, 9'd0},
    {8'hFE, 8'hC3, 2'd2, 20'hF8001, 1'b1, 16'h8001, 9'd0},
    {8'h20, 8'hC7, 2'd3, 20'h2ABCD, 1'b1, 16'hABCD, 9'd0},
    {8'h14, 8'h85, 2'd0, 20'h15ABC, 1'b1, 16'h1ABC, 9'd0},
    {8'h14, 8'h45, 2'd0, 20'h15ABC, 1'b1, 16'h1ABC, 9'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [19:0] a);
    @(negedge clk);
    host_addr = a; host_valid = 1'b1;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    host_addr = 20'h00010; #1;
    check("R1 hit", hit, 1); check("R1 ram", ram_addr, 16'h0010); check("R1 viol", viol, 0);
    host_addr = 20'h02000; #1;
    check("R1 miss", hit, 0);

    // R2/R4/R5/R6/R7 vector walk
    for (int i = 0; i < 14; i++) begin
      wr(1'b0, VEC[i][63:56]);
      wr(1'b1, VEC[i][55:48]);
      size_code = VEC[i][47:46];
      host_addr = VEC[i][45:26];
      #1;
      check($sformatf("R2/R4 hit vec %0d", i), hit, VEC[i][25]);
      check($sformatf("R5/R6/R7 ram vec %0d", i), ram_addr, VEC[i][24:9]);
    end

    // R3: size view, untouched by writes
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); size_code = 2'(c); #1;
      check("R3 size view", win_size_rd, 32'(c) << 2);
    end
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF); #1;
    check("R3 after writes", win_size_rd, 8'h0C);

    // R10: write timing
    wr(1'b1, 8'h00);
    size_code = 2'd0;
    wr(1'b0, 8'h14);
    host_addr = 20'h14100;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h40; #1;
    check("R10 old base before edge", hit, 1);
    @(negedge clk); cfg_we = 1'b0; #1;
    check("R10 new base after edge", hit, 0);
    host_addr = 20'h40100; #1;
    check("R10 new base hit", hit, 1);

    // R8: violation pulse
    wr(1'b0, 8'h14);
    access(20'h16000); #1;
    check("R8 viol pulse", viol, 1);
    @(negedge clk); #1;
    check("R8 viol one cycle", viol, 0);
    access(20'h14020); #1;
    check("R8 in-window no viol", viol, 0);
    access(20'h30000); #1;
    check("R8 outside aperture no viol", viol, 0);
    @(negedge clk); host_addr = 20'h16000; host_valid = 1'b0;
    @(negedge clk); #1;
    check("R8 no valid no viol", viol, 0);

    // R9: full 64 KB window
    size_code = 2'd3;
    wr(1'b0, 8'h20);
    access(20'h2F000); #1;
    check("R9 no viol", viol, 0);
    check("R9 hit", hit, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule